// File: doc/BRIEF.md
# Tape-Driven Table Sequencer

This block is a compact table-driven Turing machine intended for use as a sequential decoder of a slow symbol stream. It holds a tape of 256 four-bit cells under an 8-bit head that moves up or down, an 8-bit machine state, and a flag that selects where the next symbol comes from: the tape cell under the head, or an external 4-bit stream offered through a valid/ready handshake.

Each step runs in fixed phases. The cell under the head is latched. A 17-bit transition-table address is then formed from a page bit, four static option bits, the state and the symbol. The 16-bit action word that comes back is applied: the new state is loaded, a value may be written into the current cell, the head moves, and the symbol source for the next step is chosen. The transition table is a synchronous-read memory outside the block. The block issues a read strobe with the address and uses the word on the cycle that follows. A step begins only when the step enable is high while the block is idle. State 8'hFF is terminal.

Top module: `tape_automaton`

## Requirements
- R1: On reset the state is 0, the head is at 0, the symbol source is the tape, `busy_o` is low and `halted_o` is low.
- R2: A step starts only on a clock edge where `step_en` is high, the block is idle and the state is not 8'hFF. While a step runs, `busy_o` is high, and it stays high for at least three cycles. State and head change only at the end of a step.
- R3: The table address is `{page_sel, opt_bits[3:0], state[7:0], symbol[3:0]}` (bit 16 down to bit 0). `tbl_rd` is high for exactly one cycle per lookup, and `tbl_data` is taken on the following cycle.
- R4: Bits [15:8] of the action word become the new state.
- R5: When bit 3 of the action word is 1, bits [7:4] are written into the tape cell under the head as it was before the move. When bit 3 is 0, the cell keeps its value.
- R6: Action bits [2:1] move the head: 01 adds one, 10 subtracts one, and 00 or 11 leave it in place. The head wraps modulo 256 in both directions.
- R7: Bit 0 of the action word picks the symbol source for the next step: 0 uses the tape cell, 1 uses `ext_sym`. With the external source selected, the lookup waits with `ext_ready` high until `ext_valid` is high, and the symbol is taken on that cycle. `ext_ready` is low at all other times.
- R8: Once the state is 8'hFF, `halted_o` is high and `step_en` is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Request a step while idle |
| page_sel | input | 1 | Table half select (address bit 16) |
| opt_bits | input | 4 | Static option bits (address bits 15:12) |
| ext_sym | input | 4 | External stream symbol |
| ext_valid | input | 1 | External symbol is available |
| ext_ready | output | 1 | Block is waiting for an external symbol |
| tbl_addr | output | 17 | Transition table address |
| tbl_rd | output | 1 | Table read strobe |
| tbl_data | input | 16 | Action word, valid the cycle after `tbl_rd` |
| state_o | output | 8 | Current state |
| head_o | output | 8 | Current head position |
| cell_o | output | 4 | Tape cell under the head |
| busy_o | output | 1 | Step in progress |
| halted_o | output | 1 | Terminal state reached |

## Verification
The hardest situation to reach is a step stalled on the external source. It takes one step whose action word sets bit 0, followed by a step requested while `ext_valid` is low. The bench holds it there for several cycles and then offers a symbol that differs from the tape cell. It also loads a decoy table entry keyed by the tape cell, so that a lookup using the wrong source lands on a different state. Head wraparound needs a left move from cell 0 and a right move from cell 255. The bench reaches these by chaining programmed entries, using the cell value read from `cell_o` to form each table key.

// File: rtl/tape_automaton.sv
module tape_automaton #(
  parameter int SYM_W   = 4,
  parameter int STATE_W = 8,
  parameter int OPT_W   = 4,
  parameter int HEAD_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  step_en,
  input  logic                                  page_sel,
  input  logic [OPT_W-1:0]                      opt_bits,
  input  logic [SYM_W-1:0]                      ext_sym,
  input  logic                                  ext_valid,
  output logic                                  ext_ready,
  output logic [1+OPT_W+STATE_W+SYM_W-1:0]      tbl_addr,
  output logic                                  tbl_rd,
  input  logic [STATE_W+SYM_W+4-1:0]            tbl_data,
  output logic [STATE_W-1:0]                    state_o,
  output logic [HEAD_W-1:0]                     head_o,
  output logic [SYM_W-1:0]                      cell_o,
  output logic                                  busy_o,
  output logic                                  halted_o
);
  localparam int WORD_W = STATE_W + SYM_W + 4;
  localparam int CELLS  = 1 << HEAD_W;
  localparam logic [STATE_W-1:0] HALT_ST = '1;
  localparam logic [HEAD_W-1:0]  ONE     = {{(HEAD_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_LOOK, PH_COMMIT} phase_t;

  phase_t              phase;
  logic [STATE_W-1:0]  state_q;
  logic [HEAD_W-1:0]   head_q;
  logic [SYM_W-1:0]    cell_q;
  logic                src_ext;
  logic [SYM_W-1:0]    tape [CELLS];

  logic [STATE_W-1:0]  w_next;
  logic [SYM_W-1:0]    w_data;
  logic                w_we;
  logic [1:0]          w_mv;
  logic                w_src;
  logic [SYM_W-1:0]    sym;
  logic                take;
  logic [HEAD_W-1:0]   head_nx;

  assign w_next = tbl_data[WORD_W-1 -: STATE_W];
  assign w_data = tbl_data[SYM_W+3:4];
  assign w_we   = tbl_data[3];
  assign w_mv   = tbl_data[2:1];
  assign w_src  = tbl_data[0];

  assign sym       = src_ext ? ext_sym : cell_q;
  assign take      = (phase == PH_LOOK) && (!src_ext || ext_valid);
  assign tbl_addr  = {page_sel, opt_bits, state_q, sym};
  assign tbl_rd    = take;
  assign ext_ready = (phase == PH_LOOK) && src_ext;

  assign state_o  = state_q;
  assign head_o   = head_q;
  assign cell_o   = tape[head_q];
  assign busy_o   = (phase != PH_IDLE);
  assign halted_o = (state_q == HALT_ST);

  always_comb begin
    case (w_mv)
      2'b01:   head_nx = head_q + ONE;
      2'b10:   head_nx = head_q - ONE;
      default: head_nx = head_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      state_q <= '0;
      head_q  <= '0;
      cell_q  <= '0;
      src_ext <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE:   if (step_en && !halted_o) phase <= PH_READ;
        PH_READ: begin
          cell_q <= tape[head_q];
          phase  <= PH_LOOK;
        end
        PH_LOOK:   if (take) phase <= PH_COMMIT;
        PH_COMMIT: begin
          state_q <= w_next;
          head_q  <= head_nx;
          src_ext <= w_src;
          phase   <= PH_IDLE;
        end
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && phase == PH_COMMIT && w_we) tape[head_q] <= w_data;
  end
endmodule

// File: rtl/tape_automaton_chk.sv
module tape_automaton_chk #(
  parameter int STATE_W = 8,
  parameter int HEAD_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               step_en,
  input logic               busy,
  input logic               halted,
  input logic               tbl_rd,
  input logic               ext_ready,
  input logic [STATE_W-1:0] state,
  input logic [HEAD_W-1:0]  head
);
  // R2
  start_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(step_en) && !$past(halted)));
  // R2
  head_moves_in_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(head) |-> $past(busy));
  // R4
  state_moves_in_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(state) |-> $past(busy));
  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_rd |=> !tbl_rd);
  // R7
  ready_in_step_chk: assert property (@(posedge clk) disable iff (rst)
    ext_ready |-> busy);
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !busy));
endmodule

bind tape_automaton tape_automaton_chk #(.STATE_W(STATE_W), .HEAD_W(HEAD_W)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .busy(busy_o), .halted(halted_o),
  .tbl_rd(tbl_rd), .ext_ready(ext_ready), .state(state_o), .head(head_o)
);

// File: tb/tape_automaton_test.sv
module tape_automaton_test;
  logic        clk = 0, rst = 1, step_en = 0, page_sel = 0, ext_valid = 0;
  logic [3:0]  opt_bits = 0, ext_sym = 0, cell_o;
  logic        ext_ready, tbl_rd, busy_o, halted_o;
  logic [16:0] tbl_addr;
  logic [15:0] tbl_data = 0;
  logic [7:0]  state_o, head_o;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] tbl [logic [16:0]];
  logic [3:0]  c1;

  always #2 clk = ~clk;

  tape_automaton uut (
    .clk(clk), .rst(rst), .step_en(step_en), .page_sel(page_sel), .opt_bits(opt_bits),
    .ext_sym(ext_sym), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .tbl_addr(tbl_addr), .tbl_rd(tbl_rd), .tbl_data(tbl_data),
    .state_o(state_o), .head_o(head_o), .cell_o(cell_o),
    .busy_o(busy_o), .halted_o(halted_o)
  );

  always @(posedge clk)
    if (tbl_rd) tbl_data <= tbl.exists(tbl_addr) ? tbl[tbl_addr] : 16'h0000;

  function automatic logic [15:0] act(logic [7:0] nx, logic [3:0] wd, logic we,
                                      logic [1:0] mv, logic src);
    return {nx, wd, we, mv, src};
  endfunction

  task automatic prog(logic pg, logic [3:0] op, logic [7:0] st, logic [3:0] sy, logic [15:0] w);
    tbl[{pg, op, st, sy}] = w;
  endtask

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic step();
    int guard = 0;
    @(negedge clk) step_en = 1;
    @(negedge clk) step_en = 0;
    while (busy_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", state_o, 0);
    chk("R1 head", head_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 halted", halted_o, 0);
  endtask

  task automatic t_idle();
    repeat (10) @(negedge clk);
    chk("R2 no step without enable state", state_o, 0);
    chk("R2 no step without enable busy", busy_o, 0);
  endtask

  task automatic t_write_right();
    int cyc = 0;
    prog(0, 0, 8'h00, cell_o, act(8'h01, 4'hA, 1, 2'b01, 0));
    @(negedge clk) step_en = 1;
    @(negedge clk) step_en = 0;
    while (busy_o && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R2 step length", cyc, 3);
    chk("R4 next state", state_o, 8'h01);
    chk("R6 move right", head_o, 8'h01);
    chk("R7 ready low on tape source", ext_ready, 0);
  endtask

  task automatic t_left_readback();
    c1 = cell_o;
    prog(0, 0, 8'h01, c1, act(8'h02, 4'h0, 0, 2'b10, 0));
    step();
    chk("R6 move left", head_o, 8'h00);
    chk("R5 written value", cell_o, 4'hA);
    chk("R4 state", state_o, 8'h02);
    prog(0, 0, 8'h02, 4'hA, act(8'h03, 4'hF, 0, 2'b01, 0));
    step();
    chk("R5 no write when disabled", cell_o, c1);
  endtask

  task automatic t_wrap();
    prog(0, 0, 8'h03, c1, act(8'h04, 4'h3, 1, 2'b10, 0));
    step();
    prog(0, 0, 8'h04, 4'hA, act(8'h05, 4'h0, 0, 2'b10, 0));
    step();
    chk("R6 wrap down", head_o, 8'hFF);
    prog(0, 0, 8'h05, cell_o, act(8'h06, 4'h0, 0, 2'b01, 0));
    step();
    chk("R6 wrap up", head_o, 8'h00);
    chk("R5 cell kept", cell_o, 4'hA);
    prog(0, 0, 8'h06, 4'hA, act(8'h07, 4'h9, 1, 2'b11, 0));
    step();
    chk("R6 code 11 holds", head_o, 8'h00);
    chk("R5 write in place", cell_o, 4'h9);
    prog(0, 0, 8'h07, 4'h9, act(8'h07, 4'h0, 0, 2'b00, 0));
  endtask

  task automatic t_options();
    prog(1, 4'h3, 8'h07, 4'h9, act(8'h08, 4'h0, 0, 2'b00, 0));
    prog(0, 4'h0, 8'h07, 4'h9, act(8'h30, 4'h0, 0, 2'b00, 0));
    prog(0, 4'h0, 8'h08, 4'h9, act(8'h07, 4'h0, 0, 2'b00, 0));
    page_sel = 1; opt_bits = 4'h3;
    step();
    chk("R3 page and options in address", state_o, 8'h08);
    page_sel = 0; opt_bits = 4'h0;
    step();
    chk("R3 low page lookup", state_o, 8'h07);
    step();
    chk("R3 low page differs", state_o, 8'h30);
  endtask

  task automatic t_external();
    int guard = 0;
    prog(0, 0, 8'h30, 4'h9, act(8'h31, 4'h0, 0, 2'b00, 1));
    step();
    chk("R7 select ext", state_o, 8'h31);
    prog(0, 0, 8'h31, 4'h7, act(8'h32, 4'h0, 0, 2'b00, 0));
    prog(0, 0, 8'h31, 4'h9, act(8'h55, 4'h0, 0, 2'b00, 0));
    ext_sym = 4'h7;
    @(negedge clk) step_en = 1;
    @(negedge clk) step_en = 0;
    repeat (8) @(negedge clk);
    chk("R7 stalls busy", busy_o, 1);
    chk("R7 ready while waiting", ext_ready, 1);
    chk("R7 state held", state_o, 8'h31);
    ext_valid = 1;
    while (busy_o && guard < 100) begin @(negedge clk); guard++; end
    ext_valid = 0;
    chk("R7 ext symbol used", state_o, 8'h32);
    chk("R7 ready drops", ext_ready, 0);
    prog(0, 0, 8'h32, 4'h9, act(8'h33, 4'h0, 0, 2'b00, 0));
    step();
    chk("R7 back to tape", state_o, 8'h33);
  endtask

  task automatic t_halt();
    prog(0, 0, 8'h33, 4'h9, act(8'hFF, 4'h0, 0, 2'b01, 0));
    step();
    chk("R8 halt state", state_o, 8'hFF);
    chk("R8 halted flag", halted_o, 1);
    prog(0, 0, 8'hFF, cell_o, act(8'h01, 4'h0, 0, 2'b01, 0));
    @(negedge clk) step_en = 1;
    repeat (6) @(negedge clk);
    step_en = 0;
    chk("R8 no step busy", busy_o, 0);
    chk("R8 head frozen", head_o, 8'h01);
    chk("R8 state frozen", state_o, 8'hFF);
    do_reset();
    chk("R1 reset after halt state", state_o, 0);
    chk("R1 reset after halt head", head_o, 0);
    chk("R1 reset clears halt", halted_o, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_write_right();
    t_left_readback();
    t_wrap();
    t_options();
    t_external();
    t_halt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule